// File: doc/BRIEF.md
# Sequential Index-Select Downsampler

This block thins a stream of elements by a fixed ratio. Elements arrive one per time step, and the steps are grouped into frames of `FRAME_LEN` steps. In each frame, exactly one position, fixed at elaboration by `KEEP_IDX`, is passed to the downstream side. Every other element is accepted and dropped. An element may occupy `SLOT_CYCLES` clock cycles. The element position is the number of advancing cycles divided by `SLOT_CYCLES`, taken modulo the frame length.

Both sides use a ready/valid handshake. The upstream ready signal is always high, because dropped elements need no space. The selected element reaches the output in the same cycle it is presented, with no register in the data path. The position counter moves only on cycles where the clock enable and upstream valid are both high. It also stops whenever the selected element is offered while the downstream side is not ready, so that element is held until it is taken.

Top module: `idx_downsampler`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) returns the element position and the cycle-within-element count to zero.
- R2: While `dn_valid` is high, `dn_data` equals the `up_data` of the same cycle, with no added latency.
- R3: `dn_valid` is high exactly when the current element position equals `KEEP_IDX` and `up_valid` is high.
- R4: `up_ready` is high in every cycle, including during reset, clock-enable gaps and downstream stalls.
- R5: Each element position lasts `SLOT_CYCLES` advancing cycles. An advancing cycle is one with `up_valid`, `ce` and no stall all holding.
- R6: A cycle with `ce` low does not move the position or the cycle-within-element count.
- R7: A cycle with `up_valid` low does not move the counters, and `dn_valid` is low in that cycle.
- R8: A cycle with `dn_valid` high and `dn_ready` low is a stall. The counters hold, so the selected element is offered again in the next cycle.
- R9: After the last cycle of position `FRAME_LEN-1`, the position wraps to 0, and the next frame selects its own `KEEP_IDX` element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for counter advance |
| up_valid | input | 1 | Upstream element valid |
| up_ready | output | 1 | Upstream ready, constant high |
| up_data | input | DATA_W | Upstream element |
| dn_valid | output | 1 | Selected element valid |
| dn_ready | input | 1 | Downstream ready |
| dn_data | output | DATA_W | Selected element, combinational from `up_data` |

## Verification
The bench targets the edges of the counting rules. It drops `ce` and `up_valid` partway through an element. A design that counted raw clock cycles would then select the wrong position. It also withholds `dn_ready` for several cycles in the active slot. A design that kept counting there would lose the kept element, or would raise `dn_valid` in the following slot. Finally, it runs several whole frames to check the wrap. An off-by-one there would shift the selected index in the second frame, or would let the frame run one position too long.

// File: rtl/idx_downsampler.sv
module idx_downsampler #(
  parameter int DATA_W      = 8,
  parameter int FRAME_LEN   = 6,
  parameter int KEEP_IDX    = 3,
  parameter int SLOT_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  localparam int POS_W = $clog2(FRAME_LEN + 1);
  localparam int SUB_W = $clog2(SLOT_CYCLES + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] POS_KEEP = POS_W'(KEEP_IDX);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SLOT_CYCLES - 1);

  logic [POS_W-1:0] pos_q;
  logic [SUB_W-1:0] sub_q;
  logic             in_slot, stall, step;

  assign in_slot  = (pos_q == POS_KEEP);
  assign dn_valid = in_slot && up_valid;
  assign dn_data  = up_data;
  assign up_ready = 1'b1;
  assign stall    = dn_valid && !dn_ready;
  assign step     = up_valid && ce && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      sub_q <= '0;
    end else if (step) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/idx_downsampler_chk.sv
module idx_downsampler_chk #(
  parameter int FRAME_LEN   = 6,
  parameter int SLOT_CYCLES = 2,
  parameter int POS_W       = 3,
  parameter int SUB_W       = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic             up_valid,
  input logic             dn_valid,
  input logic             dn_ready,
  input logic [POS_W-1:0] pos,
  input logic [SUB_W-1:0] sub
);
  p_reset_r1: assert property (@(posedge clk) $fell(rst) |-> (pos == '0 && sub == '0));

  p_valid_needs_up_r7: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> up_valid);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> ($stable(pos) && $stable(sub)));

  p_ce_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(pos) && $stable(sub)));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> ($stable(pos) && $stable(sub)));

  p_range_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(pos) < FRAME_LEN) && (int'(sub) < SLOT_CYCLES));

  p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(pos) == FRAME_LEN - 1 && int'(sub) == SLOT_CYCLES - 1 &&
     up_valid && ce && !(dn_valid && !dn_ready)) |=> (pos == '0));
endmodule

bind idx_downsampler idx_downsampler_chk #(
  .FRAME_LEN(FRAME_LEN), .SLOT_CYCLES(SLOT_CYCLES), .POS_W(POS_W), .SUB_W(SUB_W)
) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .up_valid(up_valid), .dn_valid(dn_valid),
  .dn_ready(dn_ready), .pos(pos_q), .sub(sub_q)
);

// File: tb/test_idx_downsampler.sv
module test_idx_downsampler;
  localparam int DW = 8, N = 6, K = 3, T = 2;

  logic clk = 1'b0, rst = 1'b1, ce = 1'b0, up_valid = 1'b0, dn_ready = 1'b0;
  logic [DW-1:0] up_data = '0;
  logic up_ready, dn_valid;
  logic [DW-1:0] dn_data;
  int checks = 0, fails = 0;
  int m_pos = 0, m_sub = 0;
  int kept = 0;

  always #4 clk = ~clk;

  idx_downsampler #(.DATA_W(DW), .FRAME_LEN(N), .KEEP_IDX(K), .SLOT_CYCLES(T)) i_idx_downsampler (
    .clk(clk), .rst(rst), .ce(ce), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit e, input bit r, input logic [DW-1:0] d, input string req);
    bit ev;
    @(negedge clk);
    up_valid = v; ce = e; dn_ready = r; up_data = d;
    #1;
    ev = (m_pos == K) && v;
    chk(dn_valid == ev, {req, " R3 dn_valid"}, dn_valid, ev);
    chk(up_ready == 1'b1, "R4 up_ready", up_ready, 1);
    if (ev) begin
      chk(dn_data == d, "R2 dn_data", dn_data, d);
      if (r) kept++;
    end
    @(posedge clk);
    if (v && e && !(ev && !r)) begin
      if (m_sub == T - 1) begin
        m_sub = 0;
        m_pos = (m_pos == N - 1) ? 0 : m_pos + 1;
      end else m_sub++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_pos = 0; m_sub = 0;
    for (int i = 0; i < T; i++) step(1, 1, 1, 8'hA0 + 8'(i), "R1 after reset");
  endtask

  task automatic t_steady;
    int k0 = kept;
    for (int i = 0; i < 2 * N * T; i++) step(1, 1, 1, 8'(i), "R5 steady");
    chk(kept - k0 == 2 * T, "R9 two frames kept", kept - k0, 2 * T);
  endtask

  task automatic t_ce_gaps;
    for (int i = 0; i < N * T * 2; i++) step(1, (i % 3) != 1, 1, 8'(40 + i), "R6 ce gaps");
  endtask

  task automatic t_valid_gaps;
    for (int i = 0; i < N * T * 2; i++) step((i % 2) == 0, 1, 1, 8'(90 + i), "R7 valid gaps");
  endtask

  task automatic t_backpressure;
    while (m_pos != K) step(1, 1, 1, 8'h11, "R8 seek");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 8'h5A, "R8 stall");
    chk(m_pos == K, "R8 model held", m_pos, K);
    for (int i = 0; i < N * T; i++) step(1, 1, (i % 2) == 1, 8'(150 + i), "R8 mixed");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 3 * N * T + 1; i++) step(1, 1, 1, 8'(200 + i), "R9 wrap");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_steady();
        t_ce_gaps();
        t_valid_gaps();
        t_backpressure();
        t_wrap();
        t_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule